// File: doc/BRIEF.md
# Lockable Configuration Register Bank

This block holds two 8-bit configuration registers that a serial slave front end writes and reads by a 7-bit offset. Their contents drive control outputs: four frequency-select bits, nine clock output enables and a test-mode bit. The frequency-select bits take their start-up values from four strap inputs. The straps are captured once, on the first clock after reset is released.

Writes are guarded at two levels. Bit 0 of register 0 is a write-enable that software can set and clear. While it is clear, only that bit can be changed. Bit 7 of register 0 is a one-shot disable. Once it is set, the whole bank is frozen until the next reset. A blocked write still completes at the front end, but no register changes. Each write strobe is one transaction. The lock state seen by a transaction is the state before it, so a change to the write-enable applies from the next write onward. Reads are never blocked.

Top module: `cfg_lock_bank`

## Requirements
- R1: After reset, register 0 (offset 0) reads {bit7=0, bit6=0, bit5=1, bits[4:1]=straps, bit0=0} and register 1 (offset 1) reads 0xFF.
- R2: The four strap inputs are captured into register 0 bits [4:1] on the first clock edge after reset is released, and later strap changes have no effect.
- R3: While register 0 bit 0 (write-enable) is 0, writes to register 1 and to register 0 bits [7:1] leave them unchanged, but register 0 bit 0 takes the written value.
- R4: The write-enable value in force before a write governs that write: writing 0xFF to register 0 while locked changes only bit 0.
- R5: While write-enable is 1 and disable is 0, a write to register 1 stores the byte, and a write to register 0 stores bits [6:0] and can set bit 7. Writing bit 0 as 0 relocks later writes.
- R6: Register 0 bit 7 (disable) can be set only by a write made while unlocked. Once it is set, no write changes either register, including bit 0, until reset. Reset clears it.
- R7: The disable bit is sticky: writing 0 to it never clears it.
- R8: Reads at any offset are allowed in any lock state. Offsets 2 to 127 read 0x00, and writes to them change nothing.
- R9: The outputs track the registers combinationally: freqSel = reg0[4:1], clkEnable[7:0] = reg1, clkEnable[8] = reg0[5] and testMode = reg0[6]. The read port is combinational on rdAddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strapFs | input | 4 | Frequency-select strap pins |
| wrValid | input | 1 | One-cycle write transaction strobe |
| wrAddr | input | 7 | Write offset |
| wrData | input | 8 | Write data byte |
| rdAddr | input | 7 | Read offset |
| rdData | output | 8 | Read data, combinational on rdAddr |
| freqSel | output | 4 | Frequency-select control |
| clkEnable | output | 9 | Clock output enables, 1 = enabled |
| testMode | output | 1 | Test bit |

## Verification
A write strobe driven in one cycle updates the registers at that rising edge. Every output and the read data are therefore due from that edge onward. The bench drives each stimulus on a falling edge and samples one falling edge later, a short delay after setting rdAddr. Strap capture is due at the first rising edge after reset release, so strap checks are taken a falling edge after that edge and again after the straps have been changed.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned FS_W     = 4;
  localparam int unsigned WE_BIT   = 0;
  localparam int unsigned FS_LSB   = 1;
  localparam int unsigned EN_BIT   = 5;
  localparam int unsigned TEST_BIT = 6;
  localparam int unsigned DIS_BIT  = 7;
  localparam int unsigned REG0_OFS = 0;
  localparam int unsigned REG1_OFS = 1;
  localparam logic [DATA_W-1:0] REG0_RST = 8'h20;
  localparam logic [DATA_W-1:0] REG1_RST = 8'hFF;

  typedef struct packed {
    logic capStrap;   // load strap pins into the frequency field
    logic r0Full;     // whole of register 0 writable
    logic r0EnOnly;   // only the write-enable bit writable
    logic r1Write;    // register 1 writable
  } cfgStrobe_t;
endpackage

// File: rtl/cfg_lock_ctrl.sv
module cfg_lock_ctrl
  import cfg_lock_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrEnBit,
  input  logic              disBit,
  output cfgStrobe_t        strb
);
  logic captured;
  logic hitR0, hitR1, unlocked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) captured <= 1'b0;
    else       captured <= 1'b1;
  end

  always_comb begin
    hitR0    = wrValid && (wrAddr == ADDR_W'(REG0_OFS));
    hitR1    = wrValid && (wrAddr == ADDR_W'(REG1_OFS));
    unlocked = wrEnBit && !disBit;
    strb.capStrap = !captured;
    strb.r0Full   = hitR0 && unlocked;
    strb.r0EnOnly = hitR0 && !wrEnBit && !disBit;
    strb.r1Write  = hitR1 && unlocked;
  end

  // R5/R3: a single transaction never enables two register paths at once
  assert_single_path_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.r0Full, strb.r0EnOnly, strb.r1Write}));

  // R6: with the bank disabled no write path opens whatever arrives
  assert_no_path_when_disabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    disBit |-> !(strb.r0Full || strb.r0EnOnly || strb.r1Write));
endmodule

// File: rtl/cfg_lock_regs.sv
module cfg_lock_regs
  import cfg_lock_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned CLK_N  = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strb,
  input  logic [FS_W-1:0]   strapFs,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              wrEnBit,
  output logic              disBit,
  output logic [FS_W-1:0]   freqSel,
  output logic [CLK_N-1:0]  clkEnable,
  output logic              testMode
);
  logic [DATA_W-1:0] reg0, reg1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reg0 <= REG0_RST;
      reg1 <= REG1_RST;
    end else begin
      if (strb.r0Full) begin
        reg0[DATA_W-2:0] <= wrData[DATA_W-2:0];
        reg0[DIS_BIT]    <= reg0[DIS_BIT] | wrData[DIS_BIT];
      end else if (strb.r0EnOnly) begin
        reg0[WE_BIT] <= wrData[WE_BIT];
      end
      if (strb.capStrap) reg0[FS_LSB +: FS_W] <= strapFs;
      if (strb.r1Write) reg1 <= wrData;
    end
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_W'(REG0_OFS): rdData = reg0;
      ADDR_W'(REG1_OFS): rdData = reg1;
      default:           rdData = '0;
    endcase
  end

  assign wrEnBit  = reg0[WE_BIT];
  assign disBit   = reg0[DIS_BIT];
  assign freqSel  = reg0[FS_LSB +: FS_W];
  assign testMode = reg0[TEST_BIT];

  for (genvar i = 0; i < CLK_N; i++) begin : g_clkEn
    if (i < DATA_W) begin : g_r1
      assign clkEnable[i] = reg1[i];
    end else begin : g_r0
      assign clkEnable[i] = reg0[EN_BIT];
    end
  end

  assert_dis_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    reg0[DIS_BIT] |=> reg0[DIS_BIT]);

  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    reg0[DIS_BIT] |=> ($stable(reg0) && $stable(reg1)));

  assert_locked_r1_R3: assert property (@(posedge clk) disable iff (!rstN)
    !reg0[WE_BIT] |=> $stable(reg1));

  assert_strap_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.capStrap |=> (reg0[FS_LSB +: FS_W] == $past(strapFs)));
endmodule

// File: rtl/cfg_lock_bank.sv
module cfg_lock_bank
  import cfg_lock_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FS_W-1:0]   strapFs,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [FS_W-1:0]   freqSel,
  output logic [DATA_W:0]   clkEnable,
  output logic              testMode
);
  cfgStrobe_t strb;
  logic wrEnBit, disBit;

  cfg_lock_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrEnBit(wrEnBit), .disBit(disBit), .strb(strb)
  );

  cfg_lock_regs #(.ADDR_W(ADDR_W), .CLK_N(DATA_W + 1)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .strapFs(strapFs), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .wrEnBit(wrEnBit), .disBit(disBit),
    .freqSel(freqSel), .clkEnable(clkEnable), .testMode(testMode)
  );
endmodule

// File: tb/cfg_lock_bank_tb.sv
`timescale 1ns/1ps
module cfg_lock_bank_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] strapFs = 4'h0;
  logic       wrValid = 1'b0;
  logic [6:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [6:0] rdAddr = '0;
  logic [7:0] rdData;
  logic [3:0] freqSel;
  logic [8:0] clkEnable;
  logic       testMode;

  int errors = 0;
  int checks = 0;
  logic [7:0] m0, m1;

  always #2.5 clk = ~clk;

  cfg_lock_bank u_dut (
    .clk(clk), .rstN(rstN), .strapFs(strapFs), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .freqSel(freqSel), .clkEnable(clkEnable), .testMode(testMode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkState(input string req);
    rdAddr = 7'd0; #0.5;
    chk(req, rdData, m0);
    rdAddr = 7'd1; #0.5;
    chk(req, rdData, m1);
    chk({req, " R9 fs"}, freqSel, m0[4:1]);
    chk({req, " R9 en"}, clkEnable, {m0[5], m1});
    chk({req, " R9 tm"}, testMode, m0[6]);
  endtask

  // bench model of one write, from the requirements
  task automatic doWrite(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrValid = 1'b0;
    if (!m0[7]) begin
      if (a == 7'd0) begin
        if (m0[0]) m0 = {m0[7] | d[7], d[6:0]};
        else       m0[0] = d[0];
      end else if (a == 7'd1 && m0[0]) begin
        m1 = d;
      end
    end
  endtask

  task automatic doReset(input logic [3:0] s);
    @(negedge clk);
    rstN = 1'b0; strapFs = s;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    m0 = {3'b001, s, 1'b0};
    m1 = 8'hFF;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1, R2: every strap pattern
    for (int s = 0; s < 16; s++) begin
      doReset(4'(s));
      checkState("R1 reset");
      strapFs = ~4'(s);
      repeat (3) @(negedge clk);
      chk("R2 no resample", freqSel, s);
    end
    doReset(4'b1010);
    checkState("R1 final reset");

    // R3: locked, register 1 sweep
    for (int d = 0; d < 256; d++) begin
      doWrite(7'd1, 8'(d));
      rdAddr = 7'd1; #0.5;
      chk("R3 reg1 locked", rdData, 8'hFF);
    end
    doWrite(7'd0, 8'hFE);
    checkState("R3 reg0 locked");

    // R4: enabling write does not act on its own transaction
    doWrite(7'd0, 8'hFF);
    checkState("R4");
    chk("R4 only bit0", m0, {3'b001, 4'b1010, 1'b1});

    // R5: unlocked, register 1 sweep
    for (int d = 0; d < 256; d++) begin
      doWrite(7'd1, 8'(d));
      checkState("R5 reg1");
    end
    for (int d = 0; d < 128; d += 7) begin
      doWrite(7'd0, 8'(d) | 8'h01);
      checkState("R5 reg0");
    end
    doWrite(7'd0, 8'h00);
    checkState("R5 relock");
    doWrite(7'd1, 8'h33);
    checkState("R3 after relock");
    doWrite(7'd0, 8'h01);
    doWrite(7'd1, 8'hC3);
    checkState("R5 reg1 again");

    // R8: unimplemented offsets
    for (int a = 2; a < 128; a++) begin
      doWrite(7'(a), 8'h5A);
      rdAddr = 7'(a); #0.5;
      chk("R8 unimpl read", rdData, 0);
    end
    checkState("R8 state kept");

    // R6, R7: disable
    doWrite(7'd0, 8'hA5);
    checkState("R6 set disable");
    chk("R6 dis set", m0[7], 1);
    doWrite(7'd0, 8'h00);
    checkState("R7 write zero");
    doWrite(7'd0, 8'h7E);
    checkState("R6 reg0 frozen");
    doWrite(7'd1, 8'h00);
    checkState("R6 reg1 frozen");
    rdAddr = 7'd0; #0.5;
    chk("R8 read while disabled", rdData, m0);
    doReset(4'b0101);
    checkState("R6 reset clears");
    chk("R6 dis clear", m0[7], 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule